// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register

This block is a write-only configuration port for a clock generator. A host drives three asynchronous lines: a shift clock, a data line and a latch strobe. The block first synchronizes all three lines to its own system clock. It then shifts data bits in on each rising shift-clock edge, with the most significant bit first. A rising latch edge offers the last sixteen bits to a mode register.

The mode register holds three fields: a sampling-frequency group, a standard/double rate select, and six clock-output enables. The decoded fields drive the output ports. A word is taken only when all of these hold:
- a full sixteen bits has arrived since the previous latch edge;
- the six high bits carry the identifying pattern;
- neither the frequency code nor the rate code is a reserved value.

Any other word is dropped as a whole, and the register keeps its old contents.

Top module: `scfg_port`

## Requirements
- R1: Reset loads the defaults: group code 00 (48 kHz), standard rate (rate output 0), and all six enables set to 1.
- R2: A data bit is captured on each synchronized rising edge of the shift clock. Bits shift in MSB first, so after sixteen bits the first bit sent becomes D15 and the last bit sent becomes D0.
- R3: An accepted word sets the outputs as follows. The group output takes D1:D0. The rate output is 1 when D3:D2 = 01. Enable output bit k takes D(4+k). The order of the enables, from bit 0, is: fixed clock, 256fs, 384fs, 768fs, master clock, inverted master clock.
- R4: Group codes 00, 01 and 10 select 48, 44.1 and 32 kHz. A word with D1:D0 = 11 is discarded.
- R5: A word with rate code D3:D2 = 10 or 11 is discarded.
- R6: A word is discarded unless D15:D10 = 011100.
- R7: A latch edge that comes after fewer than sixteen bits since the previous latch edge (or since reset) is ignored.
- R8: Every latch edge clears the bit count. Bits shifted before a latch edge never count toward the next word.
- R9: If more than sixteen bits arrive before a latch edge, the last sixteen bits form the word.
- R10: The outputs change only on an accepted latch edge. Shift-clock activity alone leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| latch_i | input | 1 | Latch strobe, asynchronous |
| sclk_i | input | 1 | Shift clock, asynchronous |
| sdat_i | input | 1 | Serial data, asynchronous |
| fs_sel | output | 2 | Sampling-frequency group code |
| rate_dbl | output | 1 | 1 = double rate |
| out_en | output | 6 | Clock-output enables |

## Verification
Two cases are hard to reach from the ports. The first is a latch edge that falls after sixteen shift-clock edges in total, where those edges are split across an earlier latch edge. The stimulus sends eight bits, latches, and sends eight more. The count must restart at the first latch, so the second latch must be refused even though the shift register holds a valid word. The second case is an over-long burst of twenty bits. Its junk leading bits must fall out of the top of the register.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  localparam int WORD_W   = 16;
  localparam int PFX_W    = 6;
  localparam int EN_W     = 6;
  localparam int CNT_W    = $clog2(WORD_W + 1);
  localparam logic [PFX_W-1:0] PFX_VAL = 6'b011100;

  typedef struct packed {
    logic [1:0]      fs;
    logic            rate;
    logic [EN_W-1:0] en;
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = '{fs: 2'b00, rate: 1'b0, en: '1};

  function automatic logic word_ok(input logic [WORD_W-1:0] w);
    return (w[WORD_W-1 -: PFX_W] == PFX_VAL) && (w[1:0] != 2'b11) && !w[3];
  endfunction

  function automatic cfg_t word_fields(input logic [WORD_W-1:0] w);
    cfg_t c;
    c.fs   = w[1:0];
    c.rate = w[2];
    c.en   = w[4 +: EN_W];
    return c;
  endfunction
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= async_i[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign level_o[i] = s2;
    assign rise_o[i]  = s2 & ~s3;
  end
endmodule

// File: rtl/scfg_shift.sv
module scfg_shift
  import scfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_evt,
  input  logic              bit_in,
  input  logic              latch_evt,
  output logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              cnt_full
);
  assign cnt_full = (bit_cnt == CNT_W'(WORD_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word    <= '0;
      bit_cnt <= '0;
    end else begin
      if (shift_evt) word <= {word[WORD_W-2:0], bit_in};
      if (latch_evt)                  bit_cnt <= '0;
      else if (shift_evt && !cnt_full) bit_cnt <= bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/scfg_reg.sv
module scfg_reg
  import scfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_evt,
  input  logic              cnt_full,
  input  logic [WORD_W-1:0] word,
  output logic              accept,
  output cfg_t              cfg
);
  assign accept = latch_evt & cnt_full & word_ok(word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg <= CFG_DEFAULT;
    else if (accept) cfg <= word_fields(word);
  end
endmodule

// File: rtl/scfg_port.sv
module scfg_port
  import scfg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            latch_i,
  input  logic            sclk_i,
  input  logic            sdat_i,
  output logic [1:0]      fs_sel,
  output logic            rate_dbl,
  output logic [EN_W-1:0] out_en
);
  logic [2:0]        lvl, rise;
  logic              latch_evt, shift_evt, bit_in;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  bit_cnt;
  logic              cnt_full, accept;
  cfg_t              cfg;

  scfg_sync #(.N(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({sdat_i, sclk_i, latch_i}),
    .level_o(lvl), .rise_o(rise)
  );

  assign latch_evt = rise[0];
  assign shift_evt = rise[1];
  assign bit_in    = lvl[2];

  scfg_shift u_shift (
    .clk(clk), .rst_n(rst_n), .shift_evt(shift_evt), .bit_in(bit_in),
    .latch_evt(latch_evt), .word(word), .bit_cnt(bit_cnt), .cnt_full(cnt_full)
  );

  scfg_reg u_reg (
    .clk(clk), .rst_n(rst_n), .latch_evt(latch_evt), .cnt_full(cnt_full),
    .word(word), .accept(accept), .cfg(cfg)
  );

  assign fs_sel   = cfg.fs;
  assign rate_dbl = cfg.rate;
  assign out_en   = cfg.en;
endmodule

// File: rtl/scfg_chk.sv
module scfg_chk
  import scfg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              latch_evt,
  input logic              accept,
  input logic              cnt_full,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [WORD_W-1:0] word,
  input logic [1:0]        fs_sel,
  input logic              rate_dbl,
  input logic [EN_W-1:0]   out_en
);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable({fs_sel, rate_dbl, out_en}));
  // R7
  full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> cnt_full);
  // R8
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |=> (bit_cnt == '0));
  // R4
  fsres_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_sel != 2'b11);
  // R3
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ({fs_sel, rate_dbl, out_en} ==
                {$past(word[1:0]), $past(word[2]), $past(word[9:4])}));
  // R6
  pfx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (word[15:10] == 6'b011100));
endmodule

bind scfg_port scfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .latch_evt(latch_evt), .accept(accept),
  .cnt_full(cnt_full), .bit_cnt(bit_cnt), .word(word),
  .fs_sel(fs_sel), .rate_dbl(rate_dbl), .out_en(out_en)
);

// File: tb/sim_scfg_port.sv
module sim_scfg_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic latch_i = 1'b0, sclk_i = 1'b0, sdat_i = 1'b0;
  logic [1:0] fs_sel;
  logic rate_dbl;
  logic [5:0] out_en;

  int total = 0, bad = 0;
  bit done = 0;

  // bench model of the port
  logic [15:0] m_sh = '0;
  int          m_cnt = 0;
  logic [8:0]  m_exp = 9'b00_0_111111;

  always #4 clk = ~clk;

  scfg_port u0 (.clk(clk), .rst_n(rst_n), .latch_i(latch_i), .sclk_i(sclk_i),
                .sdat_i(sdat_i), .fs_sel(fs_sel), .rate_dbl(rate_dbl), .out_en(out_en));

  // {nbits[4:0], word[15:0]}
  localparam int NV = 10;
  localparam logic [20:0] VEC [NV] = '{
    {5'd16, 16'h72A5}, {5'd16, 16'h73F2}, {5'd16, 16'h73F3}, {5'd16, 16'h73F8},
    {5'd16, 16'h73FC}, {5'd16, 16'h63F0}, {5'd16, 16'h77F0}, {5'd16, 16'h7150},
    {5'd12, 16'h0715}, {5'd16, 16'h7004}};

  task automatic hold(); repeat (4) @(negedge clk); endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat_i = v[i]; hold();
      sclk_i = 1'b1; hold();
      sclk_i = 1'b0;
      m_sh  = {m_sh[14:0], v[i]};
      m_cnt = (m_cnt < 16) ? m_cnt + 1 : 16;
    end
  endtask

  task automatic latch();
    latch_i = 1'b1; hold();
    latch_i = 1'b0; hold(); hold();
    if (m_cnt == 16 && m_sh[15:10] == 6'b011100 && m_sh[1:0] != 2'b11 &&
        (m_sh[3:2] == 2'b00 || m_sh[3:2] == 2'b01))
      m_exp = {m_sh[1:0], m_sh[3:2] == 2'b01, m_sh[9:4]};
    m_cnt = 0;
  endtask

  task automatic chk(input string tag, input logic [8:0] exp);
    logic [8:0] got;
    got = {fs_sel, rate_dbl, out_en};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b expected=%b", tag, got, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset defaults", 9'b00_0_111111);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int k = 0; k < NV; k++) begin
      send({16'h0, VEC[k][15:0]}, int'(VEC[k][20:16]));
      latch();
      chk($sformatf("R2/R3/R4/R5/R6/R7 vector %0d", k), m_exp);
    end
    chk("R3 last vector fields", 9'b00_1_000000);

    // R10: shifting without a latch edge changes nothing
    send(32'h0000_73F1, 16);
    chk("R10 no latch", 9'b00_1_000000);
    latch();
    chk("R10 then latch applies", 9'b01_0_111111);

    // R8: 8 bits, latch, 8 bits, latch -> both refused
    send(32'h0000_0072, 8);
    latch();
    send(32'h0000_00A6, 8);
    latch();
    chk("R8 split word refused", 9'b01_0_111111);
    send(32'h0000_72A6, 16);
    latch();
    chk("R8 full word after split", 9'b10_1_101010);

    // R9: 20 bits, the last 16 form the word
    send(32'h000F_7151, 20);
    latch();
    chk("R9 long burst", 9'b01_0_010101);

    // R7: latch right after a latch with no bits
    latch();
    chk("R7 empty latch", 9'b01_0_010101);

    // R1: reset again mid-run
    rst_n = 1'b0; hold(); rst_n = 1'b1; m_cnt = 0; hold();
    m_exp = 9'b00_0_111111;
    chk("R1 reset restores defaults", m_exp);
    // R7 after reset: count is empty
    send(32'h0000_0000, 4);
    latch();
    chk("R7 short after reset", m_exp);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule